// File: doc/BRIEF.md
# Single-Address Microsequenced Multiplier Controller

This block is the control unit for a shift-and-add binary multiplier. It is built as a microsequencer: a small control store holds one microword per state, and a 3-bit address register selects the current word. Each word carries a qualifier select, a single jump target and four Moore control strobes: load operands, add multiplicand, shift, and done.

Every state tests exactly one qualifier. The qualifier can be the start request, the current multiplier bit or the last-bit flag, each true or inverted, or the constant one. A true qualifier loads the jump target into the address register. A false qualifier advances the address by one. The multiplier datapath (operand registers, adder and bit counter) lies outside the block. It supplies the multiplier bit and the last-bit flag and consumes the four strobes.

Top module: `mseq_ctrl`

## Requirements
- R1: While rst_ni is low, state_o is 0 (code 000). Because state 000 drives load_o, the outputs are load_o=1, add_o=0, shift_o=0 and done_o=0.
- R2: In state 000, when start_i is 0 on a clock edge, the state stays 000 and load_o stays 1.
- R3: In state 000, when start_i is 1 on a clock edge, the state becomes 001. State 001 asserts load_o only and moves to state 010 on the next edge whatever the inputs are.
- R4: In state 010 (no strobes), when mbit_i is 1 on a clock edge, the state becomes 101. State 101 asserts add_o only and moves to state 011 on the next edge unconditionally.
- R5: In state 010, when mbit_i is 0 on a clock edge, the state becomes 011.
- R6: State 011 asserts shift_o only. On a clock edge with last_i at 0 it returns to state 010, and with last_i at 1 it moves to state 100.
- R7: State 100 asserts done_o only and moves to state 000 on the next edge whatever the inputs are.
- R8: The four strobes depend only on state_o. A change of start_i, mbit_i or last_i between clock edges leaves them unchanged.
- R9: At most one of add_o, shift_o and done_o is high in any cycle. load_o is high only in states 000 and 001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request |
| mbit_i | input | 1 | Current multiplier bit from the datapath |
| last_i | input | 1 | High when the datapath is on its last bit |
| load_o | output | 1 | Load operands strobe |
| add_o | output | 1 | Add multiplicand strobe |
| shift_o | output | 1 | Shift strobe |
| done_o | output | 1 | Multiplication complete |
| state_o | output | 3 | Current microaddress |

## Verification
The bench builds the block at its default 3-bit address width, which covers all six used microaddresses and the two spare codes. At that width every branch edge can be reached from the ports: the wait loop, start, both outcomes of the multiplier-bit test, both outcomes of the last-bit test, and the unconditional returns. The bench also checks that the strobes stay put while inputs toggle between edges, and that a reset asserted mid-sequence takes effect at once.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  localparam int ADDR_W = 3;
  localparam int QSEL_W = 3;

  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [QSEL_W-1:0] {
    Q_ONE, Q_ST, Q_ST_N, Q_M, Q_M_N, Q_K, Q_K_N, Q_ZERO
  } qsel_e;

  typedef struct packed {
    qsel_e qsel;
    addr_t target;
    logic  load;
    logic  add;
    logic  shift;
    logic  done;
  } uword_t;

  localparam addr_t A_IDLE  = addr_t'(0);
  localparam addr_t A_LOAD2 = addr_t'(1);
  localparam addr_t A_TEST  = addr_t'(2);
  localparam addr_t A_SHIFT = addr_t'(3);
  localparam addr_t A_DONE  = addr_t'(4);
  localparam addr_t A_ADD   = addr_t'(5);
endpackage

// File: rtl/mseq_store.sv
module mseq_store
  import mseq_pkg::*;
(
  input  addr_t  addr_i,
  output uword_t word_o
);
  always_comb begin
    word_o = '{qsel: Q_ONE, target: A_IDLE, load: 1'b0, add: 1'b0, shift: 1'b0, done: 1'b0};
    case (addr_i)
      A_IDLE:  word_o = '{qsel: Q_ST_N, target: A_IDLE,  load: 1'b1, add: 1'b0, shift: 1'b0, done: 1'b0};
      A_LOAD2: word_o = '{qsel: Q_ONE,  target: A_TEST,  load: 1'b1, add: 1'b0, shift: 1'b0, done: 1'b0};
      A_TEST:  word_o = '{qsel: Q_M,    target: A_ADD,   load: 1'b0, add: 1'b0, shift: 1'b0, done: 1'b0};
      A_SHIFT: word_o = '{qsel: Q_K_N,  target: A_TEST,  load: 1'b0, add: 1'b0, shift: 1'b1, done: 1'b0};
      A_DONE:  word_o = '{qsel: Q_ONE,  target: A_IDLE,  load: 1'b0, add: 1'b0, shift: 1'b0, done: 1'b1};
      A_ADD:   word_o = '{qsel: Q_ONE,  target: A_SHIFT, load: 1'b0, add: 1'b1, shift: 1'b0, done: 1'b0};
      default: ; // spare codes jump home
    endcase
  end
endmodule

// File: rtl/mseq_qual_mux.sv
module mseq_qual_mux
  import mseq_pkg::*;
(
  input  qsel_e sel_i,
  input  logic  start_i,
  input  logic  mbit_i,
  input  logic  last_i,
  output logic  qual_o
);
  always_comb begin
    case (sel_i)
      Q_ONE:   qual_o = 1'b1;
      Q_ST:    qual_o = start_i;
      Q_ST_N:  qual_o = ~start_i;
      Q_M:     qual_o = mbit_i;
      Q_M_N:   qual_o = ~mbit_i;
      Q_K:     qual_o = last_i;
      Q_K_N:   qual_o = ~last_i;
      default: qual_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/mseq_ctrl.sv
module mseq_ctrl
  import mseq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mbit_i,
  input  logic              last_i,
  output logic              load_o,
  output logic              add_o,
  output logic              shift_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] state_o
);
  addr_t  addr_q, addr_d;
  uword_t word;
  logic   qual;

  mseq_store u_store (.addr_i(addr_q), .word_o(word));

  mseq_qual_mux u_qmux (
    .sel_i  (word.qsel),
    .start_i(start_i),
    .mbit_i (mbit_i),
    .last_i (last_i),
    .qual_o (qual)
  );

  // single-address sequencing: jump on true qualifier, else step
  assign addr_d = qual ? word.target : addr_q + addr_t'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= A_IDLE;
    else         addr_q <= addr_d;
  end

  assign state_o = addr_q;
  assign load_o  = word.load;
  assign add_o   = word.add;
  assign shift_o = word.shift;
  assign done_o  = word.done;

  a_r2_idle_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == A_IDLE && !start_i) |=> (state_o == A_IDLE && load_o));
  a_r3_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == A_IDLE && start_i) |=> (state_o == A_LOAD2));
  a_r3_load2_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == A_LOAD2) |=> (state_o == A_TEST));
  a_r4_mbit_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == A_TEST && mbit_i) |=> (state_o == A_ADD && add_o));
  a_r4_add_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == A_ADD) |=> (state_o == A_SHIFT));
  a_r5_mbit_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == A_TEST && !mbit_i) |=> (state_o == A_SHIFT));
  a_r6_loop_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == A_SHIFT && !last_i) |=> (state_o == A_TEST));
  a_r6_finish: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == A_SHIFT && last_i) |=> (state_o == A_DONE && done_o));
  a_r7_done_home: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == A_DONE) |=> (state_o == A_IDLE));
  a_r9_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({add_o, shift_o, done_o}));
  a_r9_load_states: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> (state_o == A_IDLE || state_o == A_LOAD2));
endmodule

// File: tb/mseq_ctrl_test.sv
module mseq_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st = 1'b0, mb = 1'b0, lk = 1'b0;
  logic load, add, shift, done;
  logic [2:0] state;
  int total = 0, bad = 0;
  bit fin = 1'b0;

  always #2.5 clk = ~clk;

  mseq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(st), .mbit_i(mb), .last_i(lk),
    .load_o(load), .add_o(add), .shift_o(shift), .done_o(done), .state_o(state)
  );

  // expected vector: {state, load, add, shift, done}
  task automatic chk(string req, logic [6:0] exp);
    logic [6:0] act;
    act = {state, load, add, shift, done};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    #1;
    chk("R1", 7'b000_1000);
    step();
    chk("R1", 7'b000_1000);
    rst_n = 1'b1;
  endtask

  task automatic t_wait();
    st = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R2", 7'b000_1000);
    end
  endtask

  task automatic t_start();
    st = 1'b1;
    step();
    chk("R3", 7'b001_1000);
    st = 1'b0; mb = 1'b0; lk = 1'b0;
    step();
    chk("R3", 7'b010_0000);
  endtask

  task automatic t_add_path();
    mb = 1'b1;
    step();
    chk("R4", 7'b101_0100);
    mb = 1'b0;
    step();
    chk("R4", 7'b011_0010);
  endtask

  task automatic t_shift_loop();
    lk = 1'b0;
    step();
    chk("R6", 7'b010_0000);
    mb = 1'b0;
    step();
    chk("R5", 7'b011_0010);
    lk = 1'b1;
    step();
    chk("R6", 7'b100_0001);
  endtask

  task automatic t_done();
    st = 1'b1; mb = 1'b1; lk = 1'b1;
    step();
    chk("R7", 7'b000_1000);
    step();
    chk("R3", 7'b001_1000);
  endtask

  task automatic t_moore();
    st = 1'b0; #0.5; chk("R8", 7'b001_1000);
    mb = 1'b0; #0.5; chk("R8", 7'b001_1000);
    lk = 1'b0; #0.5; chk("R8", 7'b001_1000);
    step();
    chk("R8", 7'b010_0000);
    mb = 1'b1; #0.5; chk("R8", 7'b010_0000);
    mb = 1'b0; #0.5; chk("R8", 7'b010_0000);
    step();
    chk("R5", 7'b011_0010);
    lk = 1'b1; #0.5; chk("R8", 7'b011_0010);
    lk = 1'b0; #0.5; chk("R8", 7'b011_0010);
  endtask

  task automatic t_mid_reset();
    step();
    chk("R6", 7'b010_0000);
    rst_n = 1'b0;
    #1;
    chk("R1", 7'b000_1000);
    step();
    rst_n = 1'b1;
    st = 1'b0;
    step();
    chk("R2", 7'b000_1000);
  endtask

  initial begin
    #1_000_000;
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_wait();
    t_start();
    t_add_path();
    t_shift_loop();
    t_done();
    t_moore();
    t_mid_reset();
    fin = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule